// File: doc/BRIEF.md
# Deadline Tick Timer Unit

This block holds three free-running time-base channels for a processor core: a core tick, a system tick and a hypervisor system tick. Each channel has a 63-bit up-counter and a 63-bit deadline. All three advance together on a strobe from one shared prescaler, one step for each nominal 100 MHz period. Software reads and writes either register through a small register port, which selects a channel and a field. The top bit of every 64-bit word carries the channel's disable flag and is not part of the value.

A deadline is one-shot. When it is armed and the counter reaches it, the channel fires once and then stays quiet until software writes a new deadline. A firing sets a sticky bit in a soft-interrupt status vector and sends a one-cycle wake pulse, which brings the core out of halt and makes it re-evaluate its interrupts. The core tick uses status bit 0. The system and hypervisor ticks share status bit 16. Software clears status bits by writing ones to them.

Top module: `tick_deadline_unit`

## Requirements
- R1: After reset, every channel's counter is 0, its deadline is 0, its disable flag is set and it is disarmed. Reading the counter field (field select 0) or the deadline field (field select 1) of any channel returns 64'h8000_0000_0000_0000. The status vector and wake are 0.
- R2: Every counter advances by exactly one on each prescaler strobe. The strobe comes once every PRESCALE clocks, and the first one comes PRESCALE clocks after reset is released.
- R3: A counter write (field select 0) loads bits 62:0 as the new count. Counting continues from that value at the next strobe. Bit 63 of the write becomes the channel's disable flag. A counter read returns the count in bits 62:0 and the disable flag in bit 63, so bit 63 reads 1 while the flag is set.
- R4: A deadline write (field select 1) stores bits 62:0 as the deadline and bit 63 as the disable flag. A deadline read returns {flag, deadline}.
- R5: A deadline write whose bits 62:0 are zero, or whose bit 63 is set, leaves the channel disarmed, and the channel produces no status bit and no wake.
- R6: An armed, enabled channel fires on the strobe at which its counter steps to a value at or above the deadline. A write to the channel in that cycle takes precedence and stops the firing.
- R7: A deadline written at or below the current count fires on the next strobe.
- R8: After firing, a channel stays disarmed and does not fire again until a new deadline write.
- R9: Channel select 0 (core tick) sets status bit 16'd0. Channel selects 1 (system tick) and 2 (hypervisor tick) set status bit 16. Select 3 addresses nothing: writes to it do nothing, and it reads 0.
- R10: Wake is high for exactly the one clock after an edge where at least one channel fired. Simultaneous firings produce one wake cycle.
- R11: Status bits are sticky. A clear request removes the bits set in the clear mask. A bit set by a firing in the same cycle as a clear stays set.
- R12: Setting the disable flag through a counter write suppresses an armed deadline without disarming it. Clearing the flag again lets the deadline fire when it is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_ch | input | 2 | Channel select: 0 core tick, 1 system tick, 2 hypervisor tick |
| reg_fld | input | 1 | Field select: 0 counter, 1 deadline |
| reg_wdata | input | 64 | Write data, bit 63 is the disable flag |
| reg_rdata | output | 64 | Read data of the selected channel and field (combinational) |
| sint_clr | input | 1 | Status clear request |
| sint_clr_mask | input | 17 | Write-one-to-clear mask for the status vector |
| softint | output | 17 | Sticky soft-interrupt status vector |
| wake | output | 1 | One-cycle wake pulse after a firing |

## Verification
A register write shows on the read port at the falling edge after the clock edge that takes it. A firing happens on the strobe edge where the count steps onto or past the deadline. Its status bit and its wake pulse can be seen at the falling edge that follows that same rising edge. The bench models the prescaler phase, the counters, the flags and the status vector as plain integers. It advances the model once per rising edge with the inputs that the edge sees, and compares the read data, the status vector and wake at each falling edge, so every result is checked in exactly the cycle it becomes due. Directed checks with literal values are added for the reset state, the status bit mapping, disarmed and disabled deadlines, one-shot behaviour and clear-versus-set ordering.

// File: rtl/tdu_pkg.sv
// Shared constants and types for the deadline tick timer unit.
// Assumes exactly three channels and a 17-bit soft-interrupt vector.
package tdu_pkg;

    localparam int TDU_NCH      = 3;
    localparam int TDU_CH_W     = 2;
    localparam int TDU_DATA_W   = 64;
    localparam int TDU_SINT_W   = 17;
    localparam int TDU_TICK_BIT = 0;
    localparam int TDU_SHR_BIT  = 16;

    typedef enum logic [TDU_CH_W-1:0] {
        CH_CORE  = 2'd0,
        CH_SYS   = 2'd1,
        CH_HYPER = 2'd2
    } tdu_chan_e;

    typedef enum logic {
        FLD_COUNT    = 1'b0,
        FLD_DEADLINE = 1'b1
    } tdu_field_e;

    // Status bit that a given channel sets when it fires.
    function automatic int chan_status_bit(input int ch);
        return (ch == 0) ? TDU_TICK_BIT : TDU_SHR_BIT;
    endfunction

endpackage

// File: rtl/tdu_prescaler.sv
// Divides the core clock down to one count-enable strobe per timer period.
// Assumes DIV >= 1. DIV of 1 gives a strobe on every clock.
// Counter restarts at zero on reset, so the first strobe comes DIV clocks later.
module tdu_prescaler #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic strobe_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;

    // Strobe when the phase counter sits on its last value.
    assign strobe_o = (phase_q == LAST);

    // Advance the phase, wrapping after the last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (strobe_o) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + CW'(1);
        end
    end

    generate
        if (DIV > 1) begin : g_spacing
            AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                strobe_o |=> !strobe_o); // R2
        end
    endgenerate

endmodule

// File: rtl/tdu_channel.sv
// One timer channel: a writable up-counter and a one-shot deadline.
// The top bit of each write is the channel's shared disable flag.
// Assumes writes of the counter and the deadline never arrive together.
// A write to this channel in a strobe cycle takes precedence over firing.
module tdu_channel #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_cnt,
    input  logic              wr_cmp,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cnt_rd,
    output logic [DATA_W-1:0] cmp_rd,
    output logic              fire_o
);
    localparam int VAL_W = DATA_W - 1;

    logic [VAL_W-1:0] cnt_q;
    logic [VAL_W-1:0] cmp_q;
    logic [VAL_W-1:0] cnt_inc;
    logic             dis_q;
    logic             armed_q;
    logic             reach;
    logic             flag_in;
    logic [VAL_W-1:0] val_in;

    assign flag_in = wdata[DATA_W-1];
    assign val_in  = wdata[VAL_W-1:0];

    // Count value after this strobe, and whether it meets the deadline.
    assign cnt_inc = cnt_q + VAL_W'(1);
    assign reach   = (cnt_inc >= cmp_q);

    // Fire once when armed, enabled, the strobe steps onto the deadline and no write arrives.
    assign fire_o = tick_en && armed_q && !dis_q && reach && !wr_cnt && !wr_cmp;

    // Counter: software load has priority over the strobe increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_cnt) begin
            cnt_q <= val_in;
        end else if (tick_en) begin
            cnt_q <= cnt_inc;
        end
    end

    // Deadline value holds whatever software last wrote.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (wr_cmp) begin
            cmp_q <= val_in;
        end
    end

    // Disable flag follows bit 63 of either kind of write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_q <= 1'b1;
        end else if (wr_cnt || wr_cmp) begin
            dis_q <= flag_in;
        end
    end

    // Arm on a non-zero enabled deadline write. A firing disarms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (wr_cmp) begin
            armed_q <= (|val_in) && !flag_in;
        end else if (fire_o) begin
            armed_q <= 1'b0;
        end
    end

    // Read views carry the disable flag in the top bit.
    assign cnt_rd = {dis_q, cnt_q};
    assign cmp_rd = {dis_q, cmp_q};

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt && !tick_en) |=> (cnt_q == $past(cnt_q))); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt && tick_en) |=> (cnt_q == $past(cnt_q) + VAL_W'(1))); // R2
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt_rd == $past(wdata))); // R3
    AST_ZERO_DEADLINE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmp && (val_in == '0)) |=> !armed_q); // R5
    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !armed_q); // R8

endmodule

// File: rtl/tdu_softint.sv
// Sticky soft-interrupt status vector with write-one-to-clear, plus wake pulse.
// A set in the same cycle as a clear wins.
// Wake is registered: it is high for one clock after any set.
module tdu_softint #(
    parameter int SINT_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SINT_W-1:0] set_vec,
    input  logic              clr_en,
    input  logic [SINT_W-1:0] clr_mask,
    output logic [SINT_W-1:0] sint_o,
    output logic              wake_o
);
    logic [SINT_W-1:0] sint_q;
    logic [SINT_W-1:0] clr_eff;
    logic              wake_q;

    // Effective clear mask is gated by the request.
    assign clr_eff = clr_en ? clr_mask : '0;

    // Status update: clear the masked bits, then OR in new firings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sint_q <= '0;
        end else begin
            sint_q <= (sint_q & ~clr_eff) | set_vec;
        end
    end

    // Wake pulse follows any firing by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_q <= 1'b0;
        end else begin
            wake_q <= |set_vec;
        end
    end

    assign sint_o = sint_q;
    assign wake_o = wake_q;

    AST_SINT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> (($past(sint_q) & ~sint_q) == '0)); // R11
    AST_SINT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && (set_vec == '0)) |=> ((sint_q & $past(clr_mask)) == '0)); // R11
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((sint_q & $past(set_vec)) == $past(set_vec))); // R11

endmodule

// File: rtl/tick_deadline_unit.sv
// Three-channel deadline tick timer unit.
// Channels: core tick, system tick and hypervisor tick, all stepped by one prescaler.
// Register port: channel select plus field select (counter or deadline), with a combinational read.
// Firings set sticky soft-interrupt bits (core -> TICK_BIT, others -> SHR_BIT) and pulse wake.
// Assumes the processor's priority logic and access checking live elsewhere.
module tick_deadline_unit #(
    parameter int DATA_W   = tdu_pkg::TDU_DATA_W,
    parameter int PRESCALE = 2,
    parameter int SINT_W   = tdu_pkg::TDU_SINT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_ch,
    input  logic              reg_fld,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sint_clr,
    input  logic [SINT_W-1:0] sint_clr_mask,
    output logic [SINT_W-1:0] softint,
    output logic              wake
);
    import tdu_pkg::*;

    localparam int NCH = TDU_NCH;

    logic              strobe;
    logic [NCH-1:0]    fire_w;
    logic [DATA_W-1:0] cnt_rd [NCH];
    logic [DATA_W-1:0] cmp_rd [NCH];
    logic [SINT_W-1:0] set_vec;

    tdu_prescaler #(
        .DIV (PRESCALE)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_o (strobe)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chan
            logic sel_this;
            logic wr_cnt_c;
            logic wr_cmp_c;

            // Decode this channel's write strobes.
            assign sel_this = (reg_ch == TDU_CH_W'(c));
            assign wr_cnt_c = reg_wr && sel_this && (reg_fld == FLD_COUNT);
            assign wr_cmp_c = reg_wr && sel_this && (reg_fld == FLD_DEADLINE);

            tdu_channel #(
                .DATA_W (DATA_W)
            ) u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick_en (strobe),
                .wr_cnt  (wr_cnt_c),
                .wr_cmp  (wr_cmp_c),
                .wdata   (reg_wdata),
                .cnt_rd  (cnt_rd[c]),
                .cmp_rd  (cmp_rd[c]),
                .fire_o  (fire_w[c])
            );
        end
    endgenerate

    // Map channel firings onto their status bits, the two system ticks sharing one.
    always_comb begin
        set_vec = '0;
        for (int c = 0; c < NCH; c++) begin
            if (fire_w[c]) begin
                set_vec[chan_status_bit(c)] = 1'b1;
            end
        end
    end

    // Read mux: selected channel and field, zero for an unused select.
    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (reg_ch == TDU_CH_W'(c)) begin
                reg_rdata = (reg_fld == FLD_DEADLINE) ? cmp_rd[c] : cnt_rd[c];
            end
        end
    end

    tdu_softint #(
        .SINT_W (SINT_W)
    ) u_sint (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_en   (sint_clr),
        .clr_mask (sint_clr_mask),
        .sint_o   (softint),
        .wake_o   (wake)
    );

    AST_CORE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        fire_w[0] |=> softint[TDU_TICK_BIT]); // R9
    AST_SYS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        fire_w[1] |=> softint[TDU_SHR_BIT]); // R9
    AST_HYP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        fire_w[2] |=> softint[TDU_SHR_BIT]); // R9
    AST_WAKE_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_w != '0) |=> wake); // R10
    AST_WAKE_ONLY_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_w == '0) |=> !wake); // R10
    AST_FIRE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_w != '0) |-> strobe); // R6

endmodule

// File: tb/tick_deadline_unit_test.sv
// Bench for the deadline tick timer unit: a behavioural reference model,
// advanced once per rising edge and compared on every falling edge, plus directed checks.
module tick_deadline_unit_test;

    localparam int PRESCALE = 2;
    localparam logic [63:0] FLAG = 64'h8000_0000_0000_0000;
    localparam logic [62:0] VMASK = 63'h7FFF_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_ch = 2'd0;
    logic        reg_fld = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        sint_clr = 1'b0;
    logic [16:0] sint_clr_mask = '0;
    logic [16:0] softint;
    logic        wake;

    int n_checks = 0;
    int n_fails  = 0;
    int n_cycles = 0;

    // Reference model state
    logic [62:0] m_cnt [3];
    logic [62:0] m_cmp [3];
    bit          m_dis [3];
    bit          m_arm [3];
    logic [16:0] m_sint;
    bit          m_wake;
    int          m_psc;

    always #2.5 clk = ~clk;

    tick_deadline_unit #(
        .PRESCALE (PRESCALE)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_ch        (reg_ch),
        .reg_fld       (reg_fld),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .sint_clr      (sint_clr),
        .sint_clr_mask (sint_clr_mask),
        .softint       (softint),
        .wake          (wake)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, n_cycles);
        end
    endtask

    function automatic logic [63:0] model_read();
        if (reg_ch == 2'd3) return '0;
        if (reg_fld) return {m_dis[reg_ch], m_cmp[reg_ch]};
        return {m_dis[reg_ch], m_cnt[reg_ch]};
    endfunction

    // Advance the model with the inputs seen by the coming rising edge.
    task automatic model_step();
        logic [16:0] setv;
        bit strobe;
        setv = '0;
        if (!rst_n) begin
            for (int c = 0; c < 3; c++) begin
                m_cnt[c] = '0; m_cmp[c] = '0; m_dis[c] = 1'b1; m_arm[c] = 1'b0;
            end
            m_sint = '0; m_wake = 1'b0; m_psc = 0;
            return;
        end
        strobe = (m_psc == PRESCALE - 1);
        m_psc  = strobe ? 0 : m_psc + 1;
        for (int c = 0; c < 3; c++) begin
            bit wr_this;
            logic [62:0] nxt;
            wr_this = reg_wr && (reg_ch == 2'(c));
            nxt = (m_cnt[c] + 63'd1) & VMASK;
            if (wr_this && !reg_fld) begin
                m_cnt[c] = reg_wdata[62:0];
                m_dis[c] = reg_wdata[63];
            end else begin
                if (wr_this && reg_fld) begin
                    m_cmp[c] = reg_wdata[62:0];
                    m_dis[c] = reg_wdata[63];
                    m_arm[c] = (reg_wdata[62:0] != 0) && !reg_wdata[63];
                end else if (strobe && m_arm[c] && !m_dis[c] && nxt >= m_cmp[c]) begin
                    m_arm[c] = 1'b0;
                    setv[(c == 0) ? 0 : 16] = 1'b1;
                end
                if (strobe) m_cnt[c] = nxt;
            end
        end
        if (sint_clr) m_sint = m_sint & ~sint_clr_mask;
        m_sint = m_sint | setv;
        m_wake = (setv != 0);
    endtask

    // One clock: model step, rising edge, falling edge, compare every output.
    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        n_cycles++;
        check(reg_rdata === model_read(), reg_fld ? "R4 deadline read" : "R3 counter read",
              reg_rdata, model_read());
        check(softint === m_sint, "R6 status vector", 64'(softint), 64'(m_sint));
        check(wake === m_wake, "R10 wake", 64'(wake), 64'(m_wake));
        if (n_cycles > 150000) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", n_cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input logic [1:0] ch, input logic fld, input logic [63:0] data);
        reg_wr = 1'b1; reg_ch = ch; reg_fld = fld; reg_wdata = data;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic clr(input logic [16:0] mask);
        sint_clr = 1'b1; sint_clr_mask = mask;
        cyc();
        sint_clr = 1'b0; sint_clr_mask = '0;
    endtask

    // Run until wake is seen or the limit passes. Returns 1 if seen.
    task automatic wait_wake(input int limit, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < limit && !seen; i++) begin
            cyc();
            if (wake) seen = 1'b1;
        end
    endtask

    task automatic watch_quiet(input int n, output bit any_wake);
        any_wake = 1'b0;
        for (int i = 0; i < n; i++) begin
            cyc();
            if (wake) any_wake = 1'b1;
        end
    endtask

    initial begin
        bit seen;
        @(negedge clk);
        rst_n = 1'b0;
        run(3);
        // R1: reset readouts of every channel and field
        for (int c = 0; c < 3; c++) begin
            for (int f = 0; f < 2; f++) begin
                reg_ch = 2'(c); reg_fld = f[0];
                cyc();
                check(reg_rdata === FLAG, "R1 reset read", reg_rdata, FLAG);
            end
        end
        check(softint === 17'h0, "R1 reset status", 64'(softint), 64'h0);
        check(wake === 1'b0, "R1 reset wake", 64'(wake), 64'h0);
        rst_n = 1'b1;
        reg_ch = 2'd0; reg_fld = 1'b0;
        run(2 * PRESCALE);
        // R2: counter advanced by one per strobe since reset release
        check(reg_rdata === (FLAG | 64'd2), "R2 count after two strobes", reg_rdata, FLAG | 64'd2);

        // R3: counter load, enable flag clear
        wr(2'd0, 1'b0, 64'd1000);
        check(reg_rdata === 64'd1000, "R3 loaded count", reg_rdata, 64'd1000);
        run(10);
        wr(2'd1, 1'b0, FLAG | 64'd7);
        check(reg_rdata[63] === 1'b1, "R3 disable flag reads 1", 64'(reg_rdata[63]), 64'h1);

        // R4: deadline write and read back
        wr(2'd1, 1'b1, FLAG | 64'h1234);
        check(reg_rdata === (FLAG | 64'h1234), "R4 deadline read", reg_rdata, FLAG | 64'h1234);

        // R6 / R9 / R10: core tick fires at its deadline
        wr(2'd0, 1'b0, 64'd0);
        wr(2'd0, 1'b1, 64'd20);
        reg_fld = 1'b0;
        wait_wake(100, seen);
        check(seen, "R6 core deadline fired", 64'(seen), 64'h1);
        check(softint === 17'h00001, "R9 core sets bit 0", 64'(softint), 64'h1);
        check(reg_rdata[62:0] >= 63'd20, "R6 count at deadline", reg_rdata, 64'd20);
        cyc();
        check(wake === 1'b0, "R10 wake one cycle", 64'(wake), 64'h0);

        // R8: one-shot, no second firing
        watch_quiet(200, seen);
        check(!seen, "R8 no re-fire", 64'(seen), 64'h0);
        // R11: write-one-to-clear
        clr(17'h00001);
        check(softint === 17'h0, "R11 cleared", 64'(softint), 64'h0);

        // R7: past deadline on system tick fires on next strobe
        wr(2'd1, 1'b0, 64'd500);
        wr(2'd1, 1'b1, 64'd10);
        wait_wake(PRESCALE + 1, seen);
        check(seen, "R7 past deadline fired", 64'(seen), 64'h1);
        check(softint === 17'h10000, "R9 system tick sets bit 16", 64'(softint), 64'h10000);
        clr(17'h10000);

        // R5: zero deadline and disabled deadline on hypervisor tick
        wr(2'd2, 1'b0, 64'd0);
        wr(2'd2, 1'b1, 64'd0);
        watch_quiet(40, seen);
        check(!seen && softint === 17'h0, "R5 zero deadline no fire", 64'(softint), 64'h0);
        wr(2'd2, 1'b1, FLAG | 64'd5);
        watch_quiet(40, seen);
        check(!seen && softint === 17'h0, "R5 disabled deadline no fire", 64'(softint), 64'h0);
        // R9: hypervisor tick also uses bit 16
        wr(2'd2, 1'b0, 64'd0);
        wr(2'd2, 1'b1, 64'd6);
        wait_wake(40, seen);
        check(softint === 17'h10000, "R9 hypervisor sets bit 16", 64'(softint), 64'h10000);

        // R11: set wins over clear; partial clear leaves other bits
        wr(2'd0, 1'b0, 64'd0);
        wr(2'd0, 1'b1, 64'd3);
        wait_wake(40, seen);
        check(softint === 17'h10001, "R11 both bits sticky", 64'(softint), 64'h10001);
        clr(17'h00001);
        check(softint === 17'h10000, "R11 partial clear", 64'(softint), 64'h10000);
        clr(17'h10000);
        wr(2'd0, 1'b0, 64'd0);
        wr(2'd0, 1'b1, 64'd4);
        sint_clr = 1'b1; sint_clr_mask = 17'h00001;
        seen = 1'b0;
        for (int i = 0; i < 40 && !seen; i++) begin
            cyc();
            if (wake) seen = 1'b1;
        end
        sint_clr = 1'b0; sint_clr_mask = '0;
        check(softint[0] === 1'b1, "R11 set wins over clear", 64'(softint), 64'h1);
        clr(17'h1FFFF);

        // R12: counter write with flag suppresses, clearing it re-enables
        wr(2'd0, 1'b0, 64'd0);
        wr(2'd0, 1'b1, 64'd30);
        wr(2'd0, 1'b0, FLAG);
        watch_quiet(80, seen);
        check(!seen && softint === 17'h0, "R12 flagged counter suppresses", 64'(softint), 64'h0);
        wr(2'd0, 1'b0, 64'd0);
        wait_wake(100, seen);
        check(seen && softint === 17'h1, "R12 fires after flag cleared", 64'(softint), 64'h1);
        clr(17'h1FFFF);

        // R10: simultaneous firings give one wake cycle
        for (int c = 0; c < 3; c++) wr(2'(c), 1'b0, 64'd0);
        for (int c = 0; c < 3; c++) wr(2'(c), 1'b1, 64'd20);
        wait_wake(100, seen);
        check(softint === 17'h10001, "R10 simultaneous status", 64'(softint), 64'h10001);
        cyc();
        check(wake === 1'b0, "R10 single wake cycle", 64'(wake), 64'h0);

        // R9: select 3 writes nothing and reads zero
        wr(2'd3, 1'b1, 64'd1);
        check(reg_rdata === 64'h0, "R9 unused select reads 0", reg_rdata, 64'h0);
        run(10);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule